// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Controller

The block produces four independent pulse-width-modulated pin outputs from a shared 1 MHz tick pulse. Each channel is set up through a small register window. A period value sets the length of one cycle. A duty value sets how many counts of that cycle the pin is active. A control word selects a power-of-two tick divider and inverts the pin when needed. Software writes duty and control first and the period last. The period write is the commit point. The staged settings then replace the running ones only at the next cycle boundary, so the pin never shows a mix of old and new settings.

A zero period is the stop request. The channel completes the cycle it is in and then keeps its pin low. A nonzero period written to a stopped channel starts it at once. Every channel is run by a four-state machine:

- `CH_OFF`: pin low, counters cleared.
- `CH_RUN`: counting, with nothing pending.
- `CH_UPDATE`: counting, with a staged update pending.
- `CH_STOP`: counting, with a stop pending.

The transitions are:

- `start`: `CH_OFF` to `CH_RUN`, on a nonzero period write.
- `arm`: `CH_RUN` to `CH_UPDATE`, on a nonzero period write.
- `halt`: `CH_RUN` to `CH_STOP`, on a zero period write.
- `rearm`: between `CH_UPDATE` and `CH_STOP`, on any later period write.
- `commit`: `CH_UPDATE` to `CH_RUN`, at the end of the cycle.
- `drain`: `CH_STOP` to `CH_OFF`, at the end of the cycle.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: After reset every channel is stopped, every pin is low and every mapped register reads zero.
- R2: The register offsets depend on the channel number ch (0..3). Period is at 0x400+4*ch and duty is at 0x420+4*ch, each 16 bits wide. Control is at 0x440+4*ch. In the control word, bits [1:0] are the divider exponent n and bit 5 is the invert flag. A read returns the value most recently written, not the value in use. All other bits read zero.
- R3: A write to any other address has no effect, and a read from any other address returns zero.
- R4: In normal polarity the pin is high while the cycle count is below the active duty and low for the rest of the cycle. The count runs from 0 to period-1. A duty at or above the period keeps the pin high for the whole cycle.
- R5: The cycle count advances once every 2^n tick pulses, where n is the active divider exponent.
- R6: When the active invert flag is set, a running channel drives the complement of the R4 waveform.
- R7: A nonzero period write to a stopped channel loads that period together with the latest duty and control values. The channel starts counting from 0, and the pin reflects count 0 in the cycle after the write.
- R8: On a running channel, a period write captures the period with the latest duty and control values. The captured set takes effect only when the running cycle ends. A duty or control write on its own never changes the waveform.
- R9: A zero period write lets the running cycle finish. After that the channel stops and its pin stays low. The period register reads zero at once.
- R10: The channels are independent. Writes and settings on one channel never change another channel's pin.
- R11: Suppose a period write lands in the same clock as the end of a cycle. The pending commit or stop is applied first, and the write is then handled against the resulting state. A write that meets a stop completing restarts the channel at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse at 1 MHz, the base count tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | One pin per channel |

## Verification
Read data depends only on `rd_addr` and the register state, so it is due in the same cycle the address is driven. The bench checks it one time unit after driving the address.

Each write, tick and cycle boundary updates the channel registers on the next rising edge. The pin is decoded from those registers, so its new value is due right after that edge. The bench drives all inputs on the falling edge and advances its reference model on the rising edge that consumes them. It compares the pins on the following falling edge.

Commits and stops are therefore checked in the cycle right after the tick that closes the period, never earlier.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Per-channel sequencing state
    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_RUN    = 2'd1,
        CH_UPDATE = 2'd2,
        CH_STOP   = 2'd3
    } ch_state_e;

    // Register kind selected by address bits [6:5] of the window offset
    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_DUTY   = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_kind_e;

    // Control word layout
    localparam int DIV_W   = 2;
    localparam int INV_BIT = 5;

    // Spacing between register groups inside the window
    localparam int GROUP_STRIDE = 32;
    localparam int WIN_SPAN     = 3 * GROUP_STRIDE;

endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
    import pwm_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter int                NUM_CH = 4,
    parameter logic [ADDR_W-1:0] BASE   = 12'h400,
    localparam int               CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch
);

    logic [ADDR_W-1:0] off;
    logic              in_win;
    logic [2:0]        slot;
    logic              unused_off;

    assign off    = addr - BASE;
    assign in_win = (addr >= BASE) && (off < ADDR_W'(WIN_SPAN));
    assign slot   = off[4:2];
    assign kind   = reg_kind_e'(off[6:5]);
    assign ch     = off[2 +: CH_W];
    assign hit    = in_win && (off[1:0] == 2'b00) && (int'(slot) < NUM_CH)
                    && (kind != REG_NONE);

    assign unused_off = ^{off[ADDR_W-1:7]};

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             step
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] last;

    // Last prescaler value before a step: 2^div - 1
    always_comb begin
        last = '0;
        for (int b = 0; b < PRE_W; b++) begin
            if (b < int'(div)) last[b] = 1'b1;
        end
    end

    assign step = tick && !clear && (pre == last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clear || step) begin
            pre <= '0;
        end else if (tick) begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_period,
    input  logic             wr_duty,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_inv,
    output logic [CNT_W-1:0] rd_period,
    output logic [CNT_W-1:0] rd_duty,
    output logic [DIV_W-1:0] rd_div,
    output logic             rd_inv,
    output logic             pin,
    output logic             running,
    output logic             at_end,
    output logic             step,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] act_period_o
);

    ch_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;

    // Programmed (read-back) copies
    logic [CNT_W-1:0] prg_period, prg_duty;
    logic [DIV_W-1:0] prg_div;
    logic             prg_inv;

    // Staged copies captured by the period write
    logic [CNT_W-1:0] stg_period, stg_period_n, stg_duty, stg_duty_n;
    logic [DIV_W-1:0] stg_div, stg_div_n;
    logic             stg_inv, stg_inv_n;

    // Active copies driving the waveform
    logic [CNT_W-1:0] act_period, act_period_n, act_duty, act_duty_n;
    logic [DIV_W-1:0] act_div, act_div_n;
    logic             act_inv, act_inv_n;

    pwm_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == CH_OFF),
        .tick  (tick),
        .div   (act_div),
        .step  (step)
    );

    assign at_end = step && (cnt == act_period - 1'b1);

    // Next-state: first the cycle boundary, then the period write
    always_comb begin
        state_n      = state;
        cnt_n        = cnt;
        stg_period_n = stg_period;
        stg_duty_n   = stg_duty;
        stg_div_n    = stg_div;
        stg_inv_n    = stg_inv;
        act_period_n = act_period;
        act_duty_n   = act_duty;
        act_div_n    = act_div;
        act_inv_n    = act_inv;

        unique case (state)
            CH_OFF: begin
                cnt_n = '0;
            end
            CH_RUN: begin
                if (step) cnt_n = at_end ? '0 : cnt + 1'b1;
            end
            CH_UPDATE: begin
                if (at_end) begin                  // commit
                    cnt_n        = '0;
                    act_period_n = stg_period;
                    act_duty_n   = stg_duty;
                    act_div_n    = stg_div;
                    act_inv_n    = stg_inv;
                    state_n      = CH_RUN;
                end else if (step) begin
                    cnt_n = cnt + 1'b1;
                end
            end
            CH_STOP: begin
                if (at_end) begin                  // drain
                    cnt_n   = '0;
                    state_n = CH_OFF;
                end else if (step) begin
                    cnt_n = cnt + 1'b1;
                end
            end
        endcase

        if (wr_period) begin
            if (state_n == CH_OFF) begin
                if (wr_val != '0) begin            // start
                    act_period_n = wr_val;
                    act_duty_n   = prg_duty;
                    act_div_n    = prg_div;
                    act_inv_n    = prg_inv;
                    cnt_n        = '0;
                    state_n      = CH_RUN;
                end
            end else begin                         // arm / halt / rearm
                stg_period_n = wr_val;
                stg_duty_n   = prg_duty;
                stg_div_n    = prg_div;
                stg_inv_n    = prg_inv;
                state_n      = (wr_val == '0) ? CH_STOP : CH_UPDATE;
            end
        end
    end

    // State and register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= CH_OFF;
            cnt        <= '0;
            prg_period <= '0;
            prg_duty   <= '0;
            prg_div    <= '0;
            prg_inv    <= 1'b0;
            stg_period <= '0;
            stg_duty   <= '0;
            stg_div    <= '0;
            stg_inv    <= 1'b0;
            act_period <= '0;
            act_duty   <= '0;
            act_div    <= '0;
            act_inv    <= 1'b0;
        end else begin
            state      <= state_n;
            cnt        <= cnt_n;
            stg_period <= stg_period_n;
            stg_duty   <= stg_duty_n;
            stg_div    <= stg_div_n;
            stg_inv    <= stg_inv_n;
            act_period <= act_period_n;
            act_duty   <= act_duty_n;
            act_div    <= act_div_n;
            act_inv    <= act_inv_n;
            if (wr_period) prg_period <= wr_val;
            if (wr_duty)   prg_duty   <= wr_val;
            if (wr_ctrl) begin
                prg_div <= wr_div;
                prg_inv <= wr_inv;
            end
        end
    end

    // Output process
    always_comb begin
        running = (state != CH_OFF);
        pin     = running && ((cnt < act_duty) ^ act_inv);
    end

    assign rd_period    = prg_period;
    assign rd_duty      = prg_duty;
    assign rd_div       = prg_div;
    assign rd_inv       = prg_inv;
    assign cnt_o        = cnt;
    assign act_period_o = act_period;

endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
    import pwm_pkg::*;
#(
    parameter int                NUM_CH = 4,
    parameter int                CNT_W  = 16,
    parameter int                ADDR_W = 12,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic            w_hit, r_hit;
    reg_kind_e       w_kind, r_kind;
    logic [CH_W-1:0] w_ch, r_ch;

    logic [CNT_W-1:0] rd_per [NUM_CH];
    logic [CNT_W-1:0] rd_dut [NUM_CH];
    logic [DIV_W-1:0] rd_div [NUM_CH];
    logic             rd_inv [NUM_CH];

    logic [NUM_CH-1:0]            ch_running;
    logic [NUM_CH-1:0]            ch_at_end;
    logic [NUM_CH-1:0]            ch_step;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_aper;
    logic                         unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[DATA_W-1:CNT_W]};

    pwm_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE(BASE)) u_wdec (
        .addr (wr_addr),
        .hit  (w_hit),
        .kind (w_kind),
        .ch   (w_ch)
    );

    pwm_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE(BASE)) u_rdec (
        .addr (rd_addr),
        .hit  (r_hit),
        .kind (r_kind),
        .ch   (r_ch)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic sel;
        assign sel = wr_en && w_hit && (w_ch == CH_W'(i));

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick         (tick),
            .wr_period    (sel && (w_kind == REG_PERIOD)),
            .wr_duty      (sel && (w_kind == REG_DUTY)),
            .wr_ctrl      (sel && (w_kind == REG_CTRL)),
            .wr_val       (wr_data[CNT_W-1:0]),
            .wr_div       (wr_data[DIV_W-1:0]),
            .wr_inv       (wr_data[INV_BIT]),
            .rd_period    (rd_per[i]),
            .rd_duty      (rd_dut[i]),
            .rd_div       (rd_div[i]),
            .rd_inv       (rd_inv[i]),
            .pin          (pwm_out[i]),
            .running      (ch_running[i]),
            .at_end       (ch_at_end[i]),
            .step         (ch_step[i]),
            .cnt_o        (ch_cnt[i]),
            .act_period_o (ch_aper[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (r_hit) begin
            unique case (r_kind)
                REG_PERIOD: rd_data[CNT_W-1:0] = rd_per[r_ch];
                REG_DUTY:   rd_data[CNT_W-1:0] = rd_dut[r_ch];
                REG_CTRL: begin
                    rd_data[DIV_W-1:0] = rd_div[r_ch];
                    rd_data[INV_BIT]   = rd_inv[r_ch];
                end
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_shadow_checker.sv
module pwm_shadow_checker #(
    parameter int                NUM_CH = 4,
    parameter int                CNT_W  = 16,
    parameter int                ADDR_W = 12,
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = 12'h400
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic [DATA_W-1:0]            rd_data,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0]            ch_running,
    input logic [NUM_CH-1:0]            ch_at_end,
    input logic [NUM_CH-1:0]            ch_step,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] ch_aper
);

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        logic m = 1'b0;
        for (int k = 0; k < 3; k++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (a == ADDR_W'(int'(BASE) + 32 * k + 4 * c)) m = 1'b1;
            end
        end
        return m;
    endfunction

    assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped(rd_addr) |-> (rd_data == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_count_below_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_running[i] |-> (ch_cnt[i] < ch_aper[i]));

        assert_step_only_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_step[i] |-> tick);

        assert_pin_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_running[i] |-> !pwm_out[i]);

        assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_running[i]) |-> $past(ch_at_end[i]));
    end

endmodule

bind pwm_shadow_ctrl pwm_shadow_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BASE   (BASE)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .pwm_out    (pwm_out),
    .ch_running (ch_running),
    .ch_at_end  (ch_at_end),
    .ch_step    (ch_step),
    .ch_cnt     (ch_cnt),
    .ch_aper    (ch_aper)
);

// File: tb/tb_pwm_shadow_ctrl.sv
module tb_pwm_shadow_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic [11:0] rd_addr;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    always #5 clk = ~clk;

    pwm_shadow_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R4";
    int    cycles   = 0;

    // Reference model state (st: 0 off, 1 run, 2 update pending, 3 stop pending)
    int       m_st [4];
    int       m_pre[4];
    bit [15:0] m_cnt[4], m_ap[4], m_ad[4], m_sp[4], m_sd[4], m_pp[4], m_pd[4];
    bit [1:0]  m_adv[4], m_sdv[4], m_pdv[4];
    bit        m_ai[4], m_si[4], m_pi[4];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    function automatic bit addr_mapped(input logic [11:0] a);
        bit m = 1'b0;
        for (int k = 0; k < 3; k++)
            for (int c = 0; c < 4; c++)
                if (a == 12'(12'h400 + 32 * k + 4 * c)) m = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] v = '0;
        for (int c = 0; c < 4; c++) begin
            if (a == 12'(12'h400 + 4 * c)) v = {16'h0, m_pp[c]};
            if (a == 12'(12'h420 + 4 * c)) v = {16'h0, m_pd[c]};
            if (a == 12'(12'h440 + 4 * c)) v = {26'h0, m_pi[c], 3'b000, m_pdv[c]};
        end
        return v;
    endfunction

    function automatic bit model_pin(input int c);
        return (m_st[c] != 0) && ((m_cnt[c] < m_ad[c]) ^ m_ai[c]);
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < 4; c++) begin
            m_st[c] = 0; m_pre[c] = 0; m_cnt[c] = 0;
            m_ap[c] = 0; m_ad[c] = 0; m_adv[c] = 0; m_ai[c] = 0;
            m_sp[c] = 0; m_sd[c] = 0; m_sdv[c] = 0; m_si[c] = 0;
            m_pp[c] = 0; m_pd[c] = 0; m_pdv[c] = 0; m_pi[c] = 0;
        end
    endfunction

    function automatic void model_step(input bit w, input logic [11:0] a,
                                       input logic [31:0] d, input bit tk);
        for (int c = 0; c < 4; c++) begin
            bit wp   = w && (a == 12'(12'h400 + 4 * c));
            bit wd   = w && (a == 12'(12'h420 + 4 * c));
            bit wc   = w && (a == 12'(12'h440 + 4 * c));
            bit stp  = tk && (m_st[c] != 0) && (m_pre[c] == (1 << m_adv[c]) - 1);
            bit endp = stp && (m_cnt[c] == m_ap[c] - 16'd1);
            int nst  = m_st[c];
            int npre = m_pre[c];
            if (m_st[c] == 0 || stp) npre = 0;
            else if (tk) npre = m_pre[c] + 1;
            if (stp) begin
                if (endp) begin
                    m_cnt[c] = 0;
                    if (m_st[c] == 2) begin
                        m_ap[c] = m_sp[c]; m_ad[c] = m_sd[c];
                        m_adv[c] = m_sdv[c]; m_ai[c] = m_si[c];
                        nst = 1;
                    end else if (m_st[c] == 3) begin
                        nst = 0;
                    end
                end else begin
                    m_cnt[c] = m_cnt[c] + 16'd1;
                end
            end
            if (wp) begin
                if (nst == 0) begin
                    if (d[15:0] != 0) begin
                        m_ap[c] = d[15:0]; m_ad[c] = m_pd[c];
                        m_adv[c] = m_pdv[c]; m_ai[c] = m_pi[c];
                        m_cnt[c] = 0; nst = 1;
                    end
                end else begin
                    m_sp[c] = d[15:0]; m_sd[c] = m_pd[c];
                    m_sdv[c] = m_pdv[c]; m_si[c] = m_pi[c];
                    nst = (d[15:0] == 0) ? 3 : 2;
                end
                m_pp[c] = d[15:0];
            end
            if (wd) m_pd[c] = d[15:0];
            if (wc) begin
                m_pdv[c] = d[1:0];
                m_pi[c]  = d[5];
            end
            m_st[c]  = nst;
            m_pre[c] = npre;
        end
    endfunction

    // One clock: check pins, drive inputs, check read, advance model
    task automatic cyc(input bit w, input logic [11:0] a, input logic [31:0] d,
                       input bit tk, input logic [11:0] ra);
        for (int c = 0; c < 4; c++)
            chk(cur_req, $sformatf("pin%0d", c), 32'(pwm_out[c]), 32'(model_pin(c)));
        wr_en = w; wr_addr = a; wr_data = d; tick = tk; rd_addr = ra;
        #1;
        chk(addr_mapped(ra) ? "R2" : "R3", $sformatf("read 0x%0h", ra),
            rd_data, model_read(ra));
        @(posedge clk);
        model_step(w, a, d, tk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b1, a);
    endtask

    task automatic idle(input int n, input int tick_mod);
        for (int i = 0; i < n; i++)
            cyc(1'b0, 12'h0, 32'h0, (tick_mod <= 1) ? 1'b1 : (($urandom % tick_mod) != 0), 12'h400);
    endtask

    task automatic random_phase(input int n);
        for (int i = 0; i < n; i++) begin
            int          k  = $urandom % 3;
            int          c  = $urandom % 4;
            bit          w  = ($urandom % 5) == 0;
            logic [11:0] a  = 12'(12'h400 + 32 * k + 4 * c);
            logic [31:0] d;
            logic [11:0] ra = 12'(12'h400 + 32 * ($urandom % 3) + 4 * ($urandom % 4));
            if (k == 0)      d = {$urandom, 16'h0} | 32'($urandom % 13);
            else if (k == 1) d = 32'($urandom % 15);
            else             d = $urandom;
            if (($urandom % 12) == 0) a  = 12'($urandom) & 12'hFFC;
            if (($urandom % 8) == 0)  ra = 12'($urandom);
            cyc(w, a, d, ($urandom % 4) != 0, ra);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", "pins after reset", 32'(pwm_out), 32'h0);
        for (int k = 0; k < 3; k++)
            for (int c = 0; c < 4; c++) begin
                rd_addr = 12'(12'h400 + 32 * k + 4 * c);
                #1;
                chk("R1", $sformatf("reset read 0x%0h", rd_addr), rd_data, 32'h0);
            end

        // R2: read-back of programmed values, upper bits dropped
        cur_req = "R2";
        wr(12'h420, 32'hABCD_0002);
        rd_addr = 12'h420; #1;
        chk("R2", "duty read", rd_data, 32'h0000_0002);
        wr(12'h444, 32'hFFFF_FFDE);
        rd_addr = 12'h444; #1;
        chk("R2", "ctrl read", rd_data, 32'h0000_0002);
        wr(12'h444, 32'h0000_0002);
        wr(12'h424, 32'h1);

        // R3: unmapped writes ignored, reads zero
        cur_req = "R3";
        wr(12'h410, 32'h7);
        wr(12'h460, 32'h7);
        wr(12'h402, 32'h7);
        wr(12'h000, 32'h7);
        rd_addr = 12'h410; #1;
        chk("R3", "unmapped read", rd_data, 32'h0);
        chk("R3", "pins untouched", 32'(pwm_out), 32'h0);

        // R7: start from stopped, duty 2 period 5
        cur_req = "R7";
        wr(12'h400, 32'd5);
        chk("R7", "first count high", 32'(pwm_out[0]), 32'h1);
        cur_req = "R4";
        idle(20, 1);

        // R5: divide by 4 on ch1 (ctrl written earlier), duty 1 period 3
        cur_req = "R5";
        wr(12'h404, 32'd3);
        idle(40, 3);

        // R6: inverted, duty equal to period on ch2, then duty 1
        cur_req = "R6";
        wr(12'h428, 32'd4);
        wr(12'h448, 32'h20);
        wr(12'h408, 32'd4);
        chk("R6", "inverted full duty low", 32'(pwm_out[2]), 32'h0);
        idle(6, 1);
        wr(12'h428, 32'd1);
        wr(12'h408, 32'd4);
        idle(12, 1);

        // R8: duty-only write ignored until period write, then boundary commit
        cur_req = "R8";
        wr(12'h420, 32'd4);
        idle(8, 1);
        wr(12'h400, 32'd8);
        idle(30, 2);

        // R9: stop after finishing the running cycle
        cur_req = "R9";
        wr(12'h400, 32'd0);
        rd_addr = 12'h400; #1;
        chk("R9", "period reads zero", rd_data, 32'h0);
        idle(20, 1);
        chk("R9", "pin held low", 32'(pwm_out[0]), 32'h0);

        // R11: every step ends a cycle when period is 1
        cur_req = "R11";
        wr(12'h42C, 32'd1);
        wr(12'h40C, 32'd1);
        wr(12'h40C, 32'd2);
        idle(3, 1);
        wr(12'h40C, 32'd0);
        wr(12'h40C, 32'd3);
        idle(8, 1);
        wr(12'h40C, 32'd0);
        idle(4, 1);

        // R10: random mix across channels
        cur_req = "R10";
        random_phase(4000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule